// File: doc/BRIEF.md
# Dual-Family Comparison Reference Divider

This block divides a reference clock of 2 to 20 MHz, coming from a crystal oscillator or an external source, down to the phase-comparison rate of a frequency synthesiser. A 4-bit ratio code picks one of sixteen fixed ratios. When its top bit is clear the ratio is a power of two. When its top bit is set the ratio is three, or five times a power of two. Software is expected to choose a code that keeps the comparison rate at or below 4 MHz for the reference in use.

The divided output is a single-cycle pulse once per division period. A registered square wave that toggles on every pulse is also provided for observation on a port. The code is sampled only at the edge that issues a pulse, and the new ratio applies to the period that pulse opens. A code change therefore never shortens or stretches the period already under way. A buffered-reference enable passes straight through the block. All pins are plain control and status lines: nothing flows as a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `refdiv_top`

## Requirements
- R1: While `rst_n` is low, `cmp_pulse` and `cmp_half` are 0. The first rising clock edge with `rst_n` high raises `cmp_pulse`.
- R2: With `ratio_code[3]`=0 and select `s`=`ratio_code[2:0]`, consecutive pulses are 2^(s+1) clock cycles apart, giving ratios 2, 4, 8, 16, 32, 64, 128 and 256 for s=0..7.
- R3: With `ratio_code[3]`=1, select 0 gives a spacing of 3 cycles and select s>0 gives 5·2^(s-1) cycles, giving ratios 3, 5, 10, 20, 40, 80, 160 and 320. Odd spacings are exact.
- R4: `cmp_pulse` is high for exactly one clock cycle per period.
- R5: `ratio_code` is sampled only at the edge that raises `cmp_pulse`. A change made mid-period leaves that period's length unchanged and governs the following period.
- R6: `cmp_half` toggles at exactly the edges that raise `cmp_pulse` and holds otherwise, so its period is twice the pulse spacing.
- R7: `bufref_en_o` always equals `bufref_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_code | input | 4 | Bit 3 selects the family; bits 2:0 select the ratio |
| bufref_en_i | input | 1 | Buffered-reference enable request |
| cmp_pulse | output | 1 | One-cycle comparison pulse |
| cmp_half | output | 1 | Square wave at half the comparison rate |
| bufref_en_o | output | 1 | Buffered-reference enable, passed through |

## Verification
The hardest case to reach is a code change that lands in the middle of a long period. Checking it means holding a 256-cycle ratio and switching to ratio 3 partway through. The first gap must stay 256 cycles and the next must be 3. The bench does this by synchronising on a pulse, waiting ten cycles and then switching the code. It then measures both gaps against ratios it computes itself. All sixteen codes are also visited one after another, each measured across a clean boundary. A reset is applied mid-run to confirm that the divider restarts.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int SEL_W     = 3;
  localparam int CODE_W    = SEL_W + 1;
  localparam int N_SEL     = 1 << SEL_W;
  localparam int MAX_RATIO = 5 << (N_SEL - 2);
  localparam int TC_W      = $clog2(MAX_RATIO);

  typedef struct packed {
    logic             odd_family;
    logic [SEL_W-1:0] sel;
  } ratio_code_t;
endpackage

// File: rtl/refdiv_ratio_lut.sv
module refdiv_ratio_lut
  import refdiv_pkg::*;
#(
  parameter int CNT_W = TC_W
) (
  input  ratio_code_t      code,
  output logic [CNT_W-1:0] term_cnt
);
  logic [CNT_W-1:0] pow_tc [N_SEL];
  logic [CNT_W-1:0] odd_tc [N_SEL];

  for (genvar k = 0; k < N_SEL; k++) begin : g_tc
    assign pow_tc[k] = CNT_W'((2 << k) - 1);
    if (k == 0) begin : g_three
      assign odd_tc[k] = CNT_W'(2);
    end else begin : g_five
      assign odd_tc[k] = CNT_W'((5 << (k - 1)) - 1);
    end
  end

  always_comb begin
    if (code.odd_family) term_cnt = odd_tc[code.sel];
    else                 term_cnt = pow_tc[code.sel];
  end
endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] reload,
  output logic             boundary,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;

  assign boundary = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (boundary) begin
      cnt_q <= reload;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q - 1'b1;
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/refdiv_halver.sv
module refdiv_halver (
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  output logic square
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       square <= 1'b0;
    else if (advance) square <= ~square;
  end
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
  import refdiv_pkg::*;
#(
  parameter int CNT_W = TC_W
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] ratio_code,
  input  logic              bufref_en_i,
  output logic              cmp_pulse,
  output logic              cmp_half,
  output logic              bufref_en_o
);
  logic [CNT_W-1:0] term_cnt;
  logic             boundary;

  refdiv_ratio_lut #(.CNT_W(CNT_W)) i_lut (
    .code     (ratio_code_t'(ratio_code)),
    .term_cnt (term_cnt)
  );

  refdiv_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk      (clk_ref),
    .rst_n    (rst_n),
    .reload   (term_cnt),
    .boundary (boundary),
    .tick     (cmp_pulse)
  );

  refdiv_halver i_half (
    .clk     (clk_ref),
    .rst_n   (rst_n),
    .advance (boundary),
    .square  (cmp_half)
  );

  assign bufref_en_o = bufref_en_i;
endmodule

// File: rtl/refdiv_checker.sv
module refdiv_checker (
  input logic       clk_ref,
  input logic       rst_n,
  input logic [3:0] ratio_code,
  input logic       cmp_pulse,
  input logic       cmp_half
);
  logic [3:0] code_d, lat_code;
  logic [9:0] gap, exp_r;
  logic       started;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      code_d <= '0; lat_code <= '0; gap <= '0; started <= 1'b0;
    end else begin
      code_d <= ratio_code;
      if (cmp_pulse) begin
        gap      <= 10'd1;
        lat_code <= code_d;
        started  <= 1'b1;
      end else begin
        gap <= gap + 10'd1;
      end
    end
  end

  always_comb begin
    if (!lat_code[3])              exp_r = 10'd2 << lat_code[2:0];
    else if (lat_code[2:0] == 3'd0) exp_r = 10'd3;
    else                           exp_r = 10'd5 << (lat_code[2:0] - 3'd1);
  end

  // R1: outputs quiet after an edge seen in reset
  a_r1_reset_quiet: assert property (@(posedge clk_ref)
    !rst_n |=> (!cmp_pulse && !cmp_half));

  // R4: pulse never lasts two cycles
  a_r4_single_cycle: assert property (@(posedge clk_ref) disable iff (!rst_n)
    cmp_pulse |=> !cmp_pulse);

  // R6: square wave flips with each pulse
  a_r6_toggle_on_pulse: assert property (@(posedge clk_ref) disable iff (!rst_n)
    cmp_pulse |-> (cmp_half != $past(cmp_half)));

  // R6: square wave holds between pulses
  a_r6_hold_between: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !cmp_pulse |-> $stable(cmp_half));

  // R2, R3, R5: spacing matches the code sampled at the opening edge
  a_r5_period_from_boundary_code: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (started && cmp_pulse) |-> (gap == exp_r));
endmodule

bind refdiv_top refdiv_checker i_refdiv_checker (
  .clk_ref    (clk_ref),
  .rst_n      (rst_n),
  .ratio_code (ratio_code),
  .cmp_pulse  (cmp_pulse),
  .cmp_half   (cmp_half)
);

// File: tb/test_refdiv_top.sv
`timescale 1ns/1ps
module test_refdiv_top;
  logic       clk_ref = 1'b0;
  logic       rst_n;
  logic [3:0] ratio_code = 4'h0;
  logic       bufref_en_i = 1'b0;
  logic       cmp_pulse, cmp_half, bufref_en_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  refdiv_top i_refdiv_top (
    .clk_ref(clk_ref), .rst_n(rst_n), .ratio_code(ratio_code),
    .bufref_en_i(bufref_en_i), .cmp_pulse(cmp_pulse),
    .cmp_half(cmp_half), .bufref_en_o(bufref_en_o)
  );

  always #2.5 clk_ref = ~clk_ref;

  function automatic int ratio_of(input logic [3:0] c);
    int s = int'(c[2:0]);
    if (!c[3])       return 2 ** (s + 1);
    else if (s == 0) return 3;
    else             return 5 * (2 ** (s - 1));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // behavioural model: cycles left before next pulse
  int m_left = 0;
  bit m_pulse = 0, m_half = 0;
  always @(posedge clk_ref) begin
    if (!rst_n) begin
      m_left = 0; m_pulse = 0; m_half = 0;
    end else if (m_left == 0) begin
      m_pulse = 1; m_half = !m_half; m_left = ratio_of(ratio_code) - 1;
    end else begin
      m_pulse = 0; m_left = m_left - 1;
    end
  end

  always @(negedge clk_ref) begin
    cycles++;
    if (rst_n === 1'b1) begin
      check(cmp_pulse === m_pulse, "R2 R3 R4 pulse", int'(cmp_pulse), int'(m_pulse));
      check(cmp_half === m_half, "R6 half", int'(cmp_half), int'(m_half));
    end
    check(bufref_en_o === bufref_en_i, "R7 bufref", int'(bufref_en_o), int'(bufref_en_i));
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic wait_pulse();
    do @(negedge clk_ref); while (cmp_pulse !== 1'b1);
  endtask

  task automatic gap_len(output int n);
    n = 0;
    do begin @(negedge clk_ref); n++; end while (cmp_pulse !== 1'b1);
  endtask

  task automatic measure(input logic [3:0] c, input string req);
    int n;
    @(negedge clk_ref); #1 ratio_code = c;
    wait_pulse();
    gap_len(n);
    check(n == ratio_of(c), req, n, ratio_of(c));
  endtask

  initial begin
    int n;
    rst_n = 1'b0;
    repeat (4) @(negedge clk_ref);
    // R1: quiet in reset
    check(cmp_pulse === 1'b0 && cmp_half === 1'b0, "R1 reset", int'(cmp_pulse), 0);
    #1 rst_n = 1'b1;
    @(negedge clk_ref);
    check(cmp_pulse === 1'b1, "R1 first pulse", int'(cmp_pulse), 1);

    // R2 and R3: every code, stepped both ways
    for (int i = 0; i < 8; i++) measure(4'(i), "R2 spacing");
    for (int i = 0; i < 8; i++) measure(4'(8 + i), "R3 spacing");
    for (int i = 7; i >= 0; i--) measure(4'(8 + i), "R3 spacing desc");

    // R5: mid-period change keeps the running period
    @(negedge clk_ref); #1 ratio_code = 4'h7;
    wait_pulse(); wait_pulse();
    repeat (10) @(negedge clk_ref);
    #1 ratio_code = 4'h8;
    gap_len(n);
    check(n == 256 - 10, "R5 running period kept", n, 246);
    gap_len(n);
    check(n == 3, "R5 next period uses new code", n, 3);

    // R7: enable pass-through
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_ref); #1 bufref_en_i = ~bufref_en_i;
      @(negedge clk_ref);
      check(bufref_en_o === bufref_en_i, "R7 toggle", int'(bufref_en_o), int'(bufref_en_i));
    end

    // R1: reset mid-run restarts the divider
    @(negedge clk_ref); #1 ratio_code = 4'h3;
    repeat (5) @(negedge clk_ref);
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk_ref);
    check(cmp_pulse === 1'b0 && cmp_half === 1'b0, "R1 mid reset", int'(cmp_half), 0);
    #1 rst_n = 1'b1;
    @(negedge clk_ref);
    check(cmp_pulse === 1'b1, "R1 restart pulse", int'(cmp_pulse), 1);
    gap_len(n);
    check(n == 16, "R2 after restart", n, 16);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule